// File: doc/BRIEF.md
# Banked Working Registers and Status Word

This block keeps the processor status word and the internal data RAM that backs the working registers. An access can name a working register by its three-bit index or name a byte by its direct address. A register index is turned into a RAM address through the two bank-select bits of the status word. This makes four banks of eight registers out of the bottom 32 bytes of RAM, so software can switch register context by rewriting one byte.

After each add or subtract the ALU reports its operation, operands and result. The block then updates carry, auxiliary carry and overflow. The parity bit is not stored. It is read straight from the accumulator input, so it is always current. The status word is readable and writable at direct address D0H, alongside the RAM, which sits at direct addresses below the RAM size.

Top module: `bank_psw_regs`

## Requirements
- R1: After reset the status word reads 00H, which selects bank 0.
- R2: A working register index n reaches RAM byte {RS1, RS0, n}, where RS1 is status bit 4 and RS0 is status bit 3. The same byte is visible through its direct address.
- R3: A direct write to an address below the RAM size stores the byte, and a direct read of that address returns it in the same cycle as the read request.
- R4: A direct write to D0H loads status bits 7 to 1 at the next clock edge. Bit 0 of the written data is ignored. A direct read of D0H returns the status word.
- R5: Status bit 0 (P) is 1 exactly when the accumulator input holds an odd number of ones, and it follows that input without waiting for a clock.
- R6: For alu_op 00 (add) and 01 (add with carry in = current CY), bit 7 (CY) takes the carry out of bit 7 and bit 6 (AC) takes the carry out of bit 3.
- R7: For alu_op 1x (subtract with borrow in = current CY), CY is set when the full result borrows and AC is set when the low nibble borrows.
- R8: Bit 2 (OV) is set when the signed result overflows. For add, the operand signs match and the result sign differs. For subtract, the operand signs differ and the result sign differs from the minuend's.
- R9: An ALU update leaves F0 (bit 5), RS1, RS0 and the spare bit 1 unchanged.
- R10: When a status-word write and an ALU update fall in the same cycle, CY, AC and OV come from the ALU and bits 5, 4, 3 and 1 come from the written data.
- R11: Direct writes to addresses from the RAM size up to FFH, other than D0H, change nothing, and direct reads of such addresses return 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 1 | 1: write by register index, 0: write by direct address |
| wr_idx | input | 3 | Register index for writes |
| wr_addr | input | 8 | Direct address for writes |
| wr_data | input | 8 | Write data |
| rd_reg | input | 1 | 1: read by register index, 0: read by direct address |
| rd_idx | input | 3 | Register index for reads |
| rd_addr | input | 8 | Direct address for reads |
| rd_data | output | 8 | Read data, combinational |
| acc | input | 8 | Accumulator value, used for parity |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_op | input | 2 | 00 add, 01 add with carry, 1x subtract with borrow |
| alu_a | input | 8 | First operand |
| alu_b | input | 8 | Second operand |
| alu_res | input | 8 | ALU result |
| psw | output | 8 | Status word {CY, AC, F0, RS1, RS0, OV, spare, P} |

## Verification
A software write of the status word and an ALU flag update can land on the same clock edge. The bench provokes this by asserting a write to D0H while the ALU strobe carries an add. The written data holds a CY bit that the ALU must override, and F0, bank and spare bits that the ALU must not touch. The scoreboard expects a value merged bit by bit and checks it on the following cycle. A further check confirms that a later ALU update keeps those software-owned bits.

// File: rtl/bank_psw_regs.sv
module bank_psw_regs #(
  parameter int          RAM_BYTES = 128,
  parameter logic [7:0]  PSW_ADDR  = 8'hD0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_reg,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_reg,
  input  logic [2:0] rd_idx,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [7:0] acc,
  input  logic       alu_upd,
  input  logic [1:0] alu_op,
  input  logic [7:0] alu_a,
  input  logic [7:0] alu_b,
  input  logic [7:0] alu_res,
  output logic [7:0] psw
);
  localparam int AW = $clog2(RAM_BYTES);

  logic [7:0] mem [RAM_BYTES];
  logic [7:1] st_q;

  wire [1:0] bank = st_q[4:3];
  wire [7:0] wr_phys = wr_reg ? {3'b000, bank, wr_idx} : wr_addr;
  wire [7:0] rd_phys = rd_reg ? {3'b000, bank, rd_idx} : rd_addr;
  wire wr_ram = wr_en && ({1'b0, wr_phys} < 9'(RAM_BYTES));
  wire wr_st  = wr_en && !wr_reg && (wr_addr == PSW_ADDR);
  wire rd_ram = {1'b0, rd_phys} < 9'(RAM_BYTES);
  wire rd_st  = !rd_reg && (rd_addr == PSW_ADDR);

  assign psw = {st_q, ^acc};

  always_comb begin
    if (rd_ram)      rd_data = mem[rd_phys[AW-1:0]];
    else if (rd_st)  rd_data = psw;
    else             rd_data = 8'h00;
  end

  always_ff @(posedge clk)
    if (wr_ram) mem[wr_phys[AW-1:0]] <= wr_data;

  wire       is_sub = alu_op[1];
  wire       cin    = (is_sub || alu_op[0]) ? st_q[7] : 1'b0;
  logic [8:0] full;
  logic [4:0] nib;
  logic       ov;

  always_comb begin
    if (is_sub) begin
      full = {1'b0, alu_a} - {1'b0, alu_b} - 9'(cin);
      nib  = {1'b0, alu_a[3:0]} - {1'b0, alu_b[3:0]} - 5'(cin);
      ov   = (alu_a[7] != alu_b[7]) && (alu_res[7] != alu_a[7]);
    end else begin
      full = {1'b0, alu_a} + {1'b0, alu_b} + 9'(cin);
      nib  = {1'b0, alu_a[3:0]} + {1'b0, alu_b[3:0]} + 5'(cin);
      ov   = (alu_a[7] == alu_b[7]) && (alu_res[7] != alu_a[7]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else begin
      if (wr_st) st_q <= wr_data[7:1];
      if (alu_upd) begin
        st_q[7] <= full[8];
        st_q[6] <= nib[4];
        st_q[2] <= ov;
      end
    end
  end

  AST_F0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> $stable(psw[5])); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> $stable(psw[4:3])); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_st && !alu_upd) |=> $stable({psw[7:6], psw[2]})); // R6
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && alu_op == 2'b00) |=> psw[7] == $past(({1'b0, alu_a} + {1'b0, alu_b}) > 9'h0FF)); // R6
  AST_SUB_SAME_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && alu_op[1] && alu_a == alu_b) |=> !psw[2]); // R8
  AST_PARITY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(acc) == 1) |-> psw[0]); // R5
endmodule

// File: tb/bank_psw_regs_bench.sv
module bank_psw_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_reg = 0, rd_reg = 0, alu_upd = 0;
  logic [2:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, acc = 0;
  logic [1:0] alu_op = 0;
  logic [7:0] alu_a = 0, alu_b = 0, alu_res = 0;
  logic [7:0] rd_data, psw;

  bank_psw_regs u_bank_psw_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_reg(rd_reg), .rd_idx(rd_idx),
    .rd_addr(rd_addr), .rd_data(rd_data), .acc(acc), .alu_upd(alu_upd),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res), .psw(psw));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] exp; bit on_psw; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.on_psw ? psw : rd_data;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_rd(input bit rg, input logic [2:0] idx, input logic [7:0] a,
                           input logic [7:0] e, input string tag);
    rd_reg = rg; rd_idx = idx; rd_addr = a;
    q.push_back('{e, 1'b0, tag});
    tick();
  endtask

  task automatic expect_psw(input logic [7:0] e, input string tag);
    q.push_back('{e, 1'b1, tag});
    tick();
  endtask

  task automatic wr_direct(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_reg = 0; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic wr_r(input logic [2:0] i, input logic [7:0] d);
    wr_en = 1; wr_reg = 1; wr_idx = i; wr_data = d;
    tick();
    wr_en = 0; wr_reg = 0;
  endtask

  task automatic set_alu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b, input bit c);
    alu_upd = 1; alu_op = op; alu_a = a; alu_b = b;
    alu_res = op[1] ? 8'(int'(a) - int'(b) - int'(c)) : 8'(int'(a) + int'(b) + int'(c));
  endtask

  task automatic alu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b, input bit c);
    set_alu(op, a, b, c);
    tick();
    alu_upd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_psw(8'h00, "R1 reset");
    acc = 8'h07; expect_psw(8'h01, "R5 odd acc");
    acc = 8'h03; expect_psw(8'h00, "R5 even acc");
    wr_direct(8'h05, 8'hAA); expect_rd(0, 0, 8'h05, 8'hAA, "R3 direct");
    wr_r(3'd5, 8'h11); expect_rd(0, 0, 8'h05, 8'h11, "R2 bank0 R5");
    wr_direct(8'h13, 8'h00);
    wr_direct(8'hD0, 8'h19); expect_psw(8'h18, "R4 P write ignored");
    wr_r(3'd2, 8'h5C);
    expect_rd(0, 0, 8'h1A, 8'h5C, "R2 bank3 direct");
    expect_rd(1, 3'd2, 8'h00, 8'h5C, "R2 bank3 index");
    expect_rd(0, 0, 8'hD0, 8'h18, "R4 direct read");
    alu(2'b00, 8'hFF, 8'h01, 0); expect_psw(8'hD8, "R6 add carry");
    alu(2'b01, 8'h0F, 8'h00, 1); expect_psw(8'h58, "R6 addc cin");
    alu(2'b00, 8'h7F, 8'h01, 0); expect_psw(8'h5C, "R8 add ov");
    alu(2'b10, 8'h10, 8'h01, 0); expect_psw(8'h58, "R7 sub nibble borrow");
    alu(2'b10, 8'h00, 8'h01, 0); expect_psw(8'hD8, "R7 sub borrow");
    alu(2'b10, 8'h80, 8'h01, 1); expect_psw(8'h5C, "R8 sub ov");
    wr_en = 1; wr_reg = 0; wr_addr = 8'hD0; wr_data = 8'hAA;
    set_alu(2'b00, 8'h08, 8'h08, 0);
    tick();
    wr_en = 0; alu_upd = 0;
    expect_psw(8'h6A, "R10 merged");
    alu(2'b00, 8'h01, 8'h01, 0); expect_psw(8'h2A, "R9 user bits kept");
    wr_direct(8'h93, 8'h55);
    expect_rd(0, 0, 8'h13, 8'h00, "R11 no alias");
    expect_rd(0, 0, 8'h93, 8'h00, "R11 reads zero");
    wr_direct(8'hD0, 8'h80); expect_psw(8'h80, "R4 CY by write");
    acc = 8'hFE; expect_psw(8'h81, "R5 seven ones");
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule